// File: doc/BRIEF.md
# Chainable Serial Shift Slice Bank

The block holds sixteen shift-register slices, each `SLICE_W` bits wide (32 by default), that advance together on a shared shift strobe. Each slice shifts right by one bit per strobe. Bit 0 leaves as the slice's serial output, and the new top bit comes from a selected serial source. That source is either the slice's own external data pin or the serial output of another slice. Routing slices into one another builds a longer buffer, or a ring whose loaded pattern repeats without end.

Each slice has its own configuration: a chain-enable flag, a two-bit chain-order field and a reload value for a position counter. With the flag clear the slice listens to its pin. With the flag set, the order field selects one of four fixed routings:
- a loop onto the slice itself;
- a ring of two slices;
- a ring of four slices;
- a ring of eight slices.

The position counter counts strobes down and reloads at zero. When it reloads, the slice raises a one-cycle exchange pulse that tells the surrounding logic a full word has passed. For a chain of k slices the reload value is normally 32·k−1. Configuration and slice contents are loaded through a single-beat write port.

Top module: `concat_slice_bank`

## Requirements
- R1: After a synchronous active-low reset every slice holds zero, every chain-enable flag and counter is cleared, and `exchange` is all zero.
- R2: A slice whose chain-enable flag is 0 takes its new top bit from `pin_in[i]`, whatever its order field holds.
- R3: Order 00 with chain enabled feeds a slice's own bit 0 back to its top bit, so after `SLICE_W` strobes the slice again holds the word that was loaded.
- R4: Order 01 with chain enabled takes the input from the slice whose index is the own index XOR 8 (slices are indexed 0..15, A=0 through P=15).
- R5: Order 10 with chain enabled uses the rings (g, 8+2g, 4+g, 9+2g) for g = 0..3. Each member takes the bit 0 of the member before it, and the first member takes it from the last.
- R6: Order 11 with chain enabled uses two rings of eight, each the four-ring of g followed by the four-ring of g+2 (g = 0, 1). Each member takes its predecessor's bit 0, and the first member takes it from the last.
- R7: On each strobe a slice becomes {selected bit, old[SLICE_W-1:1]}, and `slice_out[i]` always equals bit 0 of slice i.
- R8: On each strobe the slice's counter decrements; at zero it reloads the preset instead. A reload makes `exchange[i]` high for exactly the following cycle. A counter loaded with P therefore pulses on strobe P+1.
- R9: A write with `wr_is_cfg`=1 sets the flag from data bit 0, the order from bits 2:1 and the preset from bits 15:8, and loads the counter with that preset. With `wr_is_cfg`=0 the write replaces the slice contents. A write in a cycle with `shift_stb` high is ignored.
- R10: With no strobe and no write, slice contents stay unchanged and `exchange` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_stb | input | 1 | Shared shift strobe, one shift per high cycle |
| pin_in | input | 16 | External serial data bit per slice |
| wr_en | input | 1 | Write request |
| wr_is_cfg | input | 1 | 1 selects the configuration word, 0 the slice contents |
| wr_slice | input | 4 | Target slice index |
| wr_data | input | SLICE_W | Write data |
| slice_out | output | 16 | Serial output (bit 0) of each slice |
| slice_data | output | 16·SLICE_W | Contents of all slices, slice i at bits i·SLICE_W upward |
| exchange | output | 16 | One-cycle pulse per slice after a counter reload |

## Verification
Properties checked every cycle:
- each shift moves the word one place and takes the selected bit;
- contents hold when nothing happens;
- a data write lands;
- a counter never exceeds its preset;
- an exchange pulse only follows a strobe;
- a slice with the flag clear listens to its pin;
- a self-looping slice listens to its own output.

Only the bench scenarios can show the rest. That covers the ring membership for pairs, rings of four and rings of eight, a self-loop returning its pattern after a full word, and the exact strobe on which a 127 preset pulses. It also covers writes swallowed by a simultaneous strobe, and the mix of routings under random configuration.

// File: rtl/concat_slice_pkg.sv
// Shared definitions for the slice bank: slice count, chain-order codes and
// the fixed ring routing. Assumes exactly 16 slices; the ring layout is
// defined only for that count.
package concat_slice_pkg;

    localparam int NUM_SLICES = 16;
    localparam int MAX_CHAIN  = 8;

    typedef enum logic [1:0] {
        ORD_LOOP = 2'b00,
        ORD_PAIR = 2'b01,
        ORD_QUAD = 2'b10,
        ORD_OCT  = 2'b11
    } chain_ord_e;

    // Member p of the four-ring headed by slice g.
    function automatic int quad_member(input int g, input int p);
        case (p)
            0:       return g;
            1:       return 8 + 2 * g;
            2:       return 4 + g;
            default: return 9 + 2 * g;
        endcase
    endfunction

    // Member p of the eight-ring headed by slice h (h = 0 or 1).
    function automatic int oct_member(input int h, input int p);
        if (p < 4) return quad_member(h, p);
        return quad_member(h + 2, p - 4);
    endfunction

    // Index of the slice feeding slice idx for the given order code.
    function automatic int ring_pred(input int idx, input int ord);
        int r;
        r = idx;
        if (ord == 1) begin
            r = idx ^ 8;
        end else if (ord == 2) begin
            for (int g = 0; g < 4; g++)
                for (int p = 0; p < 4; p++)
                    if (quad_member(g, p) == idx) r = quad_member(g, (p + 3) % 4);
        end else if (ord == 3) begin
            for (int h = 0; h < 2; h++)
                for (int p = 0; p < 8; p++)
                    if (oct_member(h, p) == idx) r = oct_member(h, (p + 7) % 8);
        end
        return r;
    endfunction

endpackage

// File: rtl/slice_router.sv
// Serial input selector for all slices. Purely combinational: each slice's
// new top bit comes from its pin (chain disabled) or from the bit 0 of the
// predecessor chosen by its order field. Predecessors are fixed at
// elaboration from the package ring tables.
module slice_router
    import concat_slice_pkg::*;
(
    input  logic [NUM_SLICES-1:0]      pin_in,
    input  logic [NUM_SLICES-1:0]      slice_lsb,
    input  logic [NUM_SLICES-1:0]      cfg_en,
    input  logic [NUM_SLICES-1:0][1:0] cfg_ord,
    output logic [NUM_SLICES-1:0]      ser_in
);

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_route
        localparam int P_PAIR = ring_pred(i, 1);
        localparam int P_QUAD = ring_pred(i, 2);
        localparam int P_OCT  = ring_pred(i, 3);

        // Pick slice i's serial source from pin or ring predecessor.
        always_comb begin
            if (!cfg_en[i]) begin
                ser_in[i] = pin_in[i];
            end else begin
                case (chain_ord_e'(cfg_ord[i]))
                    ORD_LOOP: ser_in[i] = slice_lsb[i];
                    ORD_PAIR: ser_in[i] = slice_lsb[P_PAIR];
                    ORD_QUAD: ser_in[i] = slice_lsb[P_QUAD];
                    default:  ser_in[i] = slice_lsb[P_OCT];
                endcase
            end
        end
    end

endmodule

// File: rtl/slice_cell.sv
// One shift slice with its configuration and position counter. Shifts right
// on a strobe, loads contents or configuration on a write. Assumes the
// caller never asserts a write together with a strobe.
module slice_cell #(
    parameter int SLICE_W  = 32,
    parameter int PRESET_W = 8,
    parameter int PRE_LSB  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_stb,
    input  logic               wr_cfg,
    input  logic               wr_dat,
    input  logic [SLICE_W-1:0] wr_data,
    input  logic               ser_in,
    output logic [SLICE_W-1:0] data_q,
    output logic               cfg_en,
    output logic [1:0]         cfg_ord,
    output logic               xchg
);

    logic [PRESET_W-1:0] preset_q;
    logic [PRESET_W-1:0] pos_q;

    // Slice contents: shift on strobe, replace on data write.
    always_ff @(posedge clk) begin
        if (!rst_n)         data_q <= '0;
        else if (shift_stb) data_q <= {ser_in, data_q[SLICE_W-1:1]};
        else if (wr_dat)    data_q <= wr_data;
    end

    // Configuration fields: flag, order and counter reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            cfg_ord  <= 2'b00;
            preset_q <= '0;
        end else if (wr_cfg) begin
            cfg_en   <= wr_data[0];
            cfg_ord  <= wr_data[2:1];
            preset_q <= wr_data[PRE_LSB +: PRESET_W];
        end
    end

    // Position counter with reload and one-cycle exchange pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            xchg  <= 1'b0;
        end else begin
            xchg <= 1'b0;
            if (shift_stb) begin
                if (pos_q == '0) begin
                    pos_q <= preset_q;
                    xchg  <= 1'b1;
                end else begin
                    pos_q <= pos_q - 1'b1;
                end
            end else if (wr_cfg) begin
                pos_q <= wr_data[PRE_LSB +: PRESET_W];
            end
        end
    end

    assert_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |=> (data_q[SLICE_W-2:0] == $past(data_q[SLICE_W-1:1]))
                      && (data_q[SLICE_W-1] == $past(ser_in)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_stb && !wr_dat) |=> $stable(data_q));

    assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && !shift_stb) |=> (data_q == $past(wr_data)));

    assert_pos_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= preset_q);

    assert_xchg_after_stb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xchg |-> $past(shift_stb));

endmodule

// File: rtl/concat_slice_bank.sv
// Top of the chainable slice bank. Decodes the write port (writes are
// dropped in a strobe cycle), instantiates the slices and the serial input
// router, and flattens the slice contents onto one output bus.
module concat_slice_bank
    import concat_slice_pkg::*;
#(
    parameter int SLICE_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_stb,
    input  logic [NUM_SLICES-1:0]         pin_in,
    input  logic                          wr_en,
    input  logic                          wr_is_cfg,
    input  logic [$clog2(NUM_SLICES)-1:0] wr_slice,
    input  logic [SLICE_W-1:0]            wr_data,
    output logic [NUM_SLICES-1:0]         slice_out,
    output logic [NUM_SLICES*SLICE_W-1:0] slice_data,
    output logic [NUM_SLICES-1:0]         exchange
);

    localparam int IDX_W    = $clog2(NUM_SLICES);
    localparam int PRESET_W = $clog2(SLICE_W * MAX_CHAIN);
    localparam int PRE_LSB  = 8;

    logic                      wr_ok;
    logic [NUM_SLICES-1:0]      ser_in;
    logic [NUM_SLICES-1:0]      cfg_en;
    logic [NUM_SLICES-1:0][1:0] cfg_ord;

    // Writes only act between strobes.
    assign wr_ok = wr_en && !shift_stb;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        logic [SLICE_W-1:0] dq;

        slice_cell #(
            .SLICE_W  (SLICE_W),
            .PRESET_W (PRESET_W),
            .PRE_LSB  (PRE_LSB)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .shift_stb (shift_stb),
            .wr_cfg    (wr_ok && wr_is_cfg && (wr_slice == MY_IDX)),
            .wr_dat    (wr_ok && !wr_is_cfg && (wr_slice == MY_IDX)),
            .wr_data   (wr_data),
            .ser_in    (ser_in[i]),
            .data_q    (dq),
            .cfg_en    (cfg_en[i]),
            .cfg_ord   (cfg_ord[i]),
            .xchg      (exchange[i])
        );

        assign slice_data[i*SLICE_W +: SLICE_W] = dq;
        assign slice_out[i] = dq[0];

        assert_pin_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[i] |-> (ser_in[i] == pin_in[i]));

        assert_self_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_en[i] && cfg_ord[i] == 2'b00) |-> (ser_in[i] == slice_out[i]));
    end

    slice_router u_router (
        .pin_in    (pin_in),
        .slice_lsb (slice_out),
        .cfg_en    (cfg_en),
        .cfg_ord   (cfg_ord),
        .ser_in    (ser_in)
    );

endmodule

// File: tb/test_concat_slice_bank.sv
`timescale 1ns/1ps
module test_concat_slice_bank;

    localparam int N = 16;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           shift_stb;
    logic [N-1:0]   pin_in;
    logic           wr_en;
    logic           wr_is_cfg;
    logic [3:0]     wr_slice;
    logic [W-1:0]   wr_data;
    logic [N-1:0]   slice_out;
    logic [N*W-1:0] slice_data;
    logic [N-1:0]   exchange;

    always #2 clk = ~clk;

    concat_slice_bank #(.SLICE_W(W)) i_concat_slice_bank (
        .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .pin_in(pin_in),
        .wr_en(wr_en), .wr_is_cfg(wr_is_cfg), .wr_slice(wr_slice),
        .wr_data(wr_data), .slice_out(slice_out), .slice_data(slice_data),
        .exchange(exchange)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state, from the requirements.
    logic [W-1:0] m_data [N];
    bit           m_en   [N];
    int           m_ord  [N];
    int           m_pre  [N];
    int           m_pos  [N];
    logic [N-1:0] m_x;

    int quad_tbl [4][4] = '{'{0, 8, 4, 9}, '{1, 10, 5, 11}, '{2, 12, 6, 13}, '{3, 14, 7, 15}};
    int oct_tbl  [2][8] = '{'{0, 8, 4, 9, 2, 12, 6, 13}, '{1, 10, 5, 11, 3, 14, 7, 15}};

    function automatic int src_of(int i, int ord);
        int r = i;
        if (ord == 1) r = i ^ 8;
        if (ord == 2)
            for (int g = 0; g < 4; g++)
                for (int p = 0; p < 4; p++)
                    if (quad_tbl[g][p] == i) r = quad_tbl[g][(p == 0) ? 3 : p - 1];
        if (ord == 3)
            for (int h = 0; h < 2; h++)
                for (int p = 0; p < 8; p++)
                    if (oct_tbl[h][p] == i) r = oct_tbl[h][(p == 0) ? 7 : p - 1];
        return r;
    endfunction

    function automatic void model_strobe(logic [N-1:0] pins);
        logic [W-1:0] nd [N];
        logic b;
        for (int i = 0; i < N; i++) begin
            b = m_en[i] ? m_data[src_of(i, m_ord[i])][0] : pins[i];
            nd[i] = {b, m_data[i][W-1:1]};
        end
        for (int i = 0; i < N; i++) begin
            m_data[i] = nd[i];
            m_x[i] = (m_pos[i] == 0);
            m_pos[i] = (m_pos[i] == 0) ? m_pre[i] : m_pos[i] - 1;
        end
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        for (int i = 0; i < N; i++)
            check(req, slice_data[i*W +: W], m_data[i], $sformatf("slice %0d data", i));
        check(req, {16'h0, slice_out}, {16'h0, 16'(0)} | W'(get_lsbs()), "serial out (R7)");
        check(req, {16'h0, exchange}, {16'h0, m_x}, "exchange");
    endtask

    function automatic logic [N-1:0] get_lsbs();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_data[i][0];
        return v;
    endfunction

    task automatic strobe(logic [N-1:0] pins, string req);
        @(negedge clk);
        shift_stb = 1'b1;
        pin_in    = pins;
        model_strobe(pins);
        @(negedge clk);
        shift_stb = 1'b0;
        check_state(req);
    endtask

    task automatic write(bit is_cfg, int idx, logic [W-1:0] d, bit with_stb, string req);
        logic [N-1:0] pins;
        pins = N'($urandom);
        @(negedge clk);
        wr_en = 1'b1; wr_is_cfg = is_cfg; wr_slice = 4'(idx); wr_data = d;
        shift_stb = with_stb; pin_in = pins;
        if (with_stb) begin
            model_strobe(pins);
        end else begin
            m_x = '0;
            if (is_cfg) begin
                m_en[idx]  = d[0];
                m_ord[idx] = int'(d[2:1]);
                m_pre[idx] = int'(d[15:8]);
                m_pos[idx] = int'(d[15:8]);
            end else begin
                m_data[idx] = d;
            end
        end
        @(negedge clk);
        wr_en = 1'b0; shift_stb = 1'b0;
        check_state(req);
    endtask

    function automatic logic [W-1:0] cfg_word(bit en, int ord, int pre);
        return {16'h0, 8'(pre), 5'h0, 2'(ord), en};
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int first_pulse;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; shift_stb = 1'b0; pin_in = '0; wr_en = 1'b0;
        wr_is_cfg = 1'b0; wr_slice = '0; wr_data = '0;
        for (int i = 0; i < N; i++) begin
            m_data[i] = '0; m_en[i] = 0; m_ord[i] = 0; m_pre[i] = 0; m_pos[i] = 0;
        end
        m_x = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1");

        // R2: flag clear, order field set to 11, still reads its pin.
        write(1, 3, cfg_word(0, 3, 0), 0, "R9");
        write(0, 3, 32'h8000_0001, 0, "R9");
        strobe(16'h0008, "R2");
        check("R2", slice_data[3*W +: W], 32'hC000_0000, "pin bit shifted in");
        strobe(16'h0000, "R2");

        // R3: self-loop returns the pattern after a full word.
        write(1, 5, cfg_word(1, 0, 31), 0, "R9");
        write(0, 5, 32'hA5C3_0F17, 0, "R9");
        for (int k = 0; k < W; k++) strobe(N'($urandom), "R3");
        check("R3", slice_data[5*W +: W], 32'hA5C3_0F17, "self-loop pattern after 32 strobes");

        // R4: pair of slices 6 and 14.
        write(1, 6, cfg_word(0, 1, 63), 0, "R9");
        write(1, 14, cfg_word(1, 1, 63), 0, "R9");
        write(0, 6, 32'h1234_5678, 0, "R9");
        write(0, 14, 32'h0000_0000, 0, "R9");
        for (int k = 0; k < 40; k++) strobe(N'($urandom), "R4");

        // R5 and R8: ring A, I, E, J with preset 127.
        write(1, 0, cfg_word(0, 2, 127), 0, "R9");
        write(1, 8, cfg_word(1, 2, 127), 0, "R9");
        write(1, 4, cfg_word(1, 2, 127), 0, "R9");
        write(1, 9, cfg_word(1, 2, 127), 0, "R9");
        first_pulse = 0;
        for (int k = 1; k <= 130; k++) begin
            strobe(N'($urandom), "R5");
            if (exchange[8] && first_pulse == 0) first_pulse = k;
        end
        check("R8", W'(first_pulse), W'(128), "strobe index of first exchange");

        // R6: eight-ring headed by slice 1.
        write(1, 1, cfg_word(0, 3, 255), 0, "R9");
        foreach (oct_tbl[1][p]) if (p > 0) write(1, oct_tbl[1][p], cfg_word(1, 3, 255), 0, "R9");
        write(0, 1, 32'hF00D_BEEF, 0, "R9");
        for (int k = 0; k < 40; k++) strobe(N'($urandom), "R6");

        // R9: write during a strobe is dropped.
        write(0, 2, 32'hDEAD_0000, 1, "R9");
        write(1, 2, cfg_word(1, 0, 5), 1, "R9");
        strobe(16'hFFFF, "R9");

        // R10: idle cycles hold everything.
        m_x = '0;
        repeat (4) @(negedge clk);
        check_state("R10");

        // Random mix of strobes, writes and configurations.
        for (int k = 0; k < 1500; k++) begin
            int sel = $urandom_range(0, 99);
            int idx = $urandom_range(0, N - 1);
            if (sel < 60)
                strobe(N'($urandom), "R7");
            else if (sel < 80)
                write(0, idx, $urandom, 0, "R9");
            else if (sel < 95)
                write(1, idx, cfg_word(1'($urandom), $urandom_range(0, 3), $urandom_range(0, 15)), 0, "R7");
            else
                write(1'($urandom), idx, $urandom, 1, "R9");
        end

        summary();
        $finish;
    end

endmodule